// File: doc/BRIEF.md
# Interrupt Source to Priority Level Mapper

This block gathers eight level-sensitive interrupt request lines into a pending mask and turns them into sixteen per-priority request lines for a processor. Each source has a fixed priority level taken from a sparse, non-monotonic table. A level line is high when at least one pending source mapped to that level is high and interrupts are not globally switched off. Two sources map to level 0, which means "no interrupt", so they never raise a line.

One 8-bit control register sits behind a single-address strobe port. Its top bit is a global switch that forces every level line low while it is set. The other seven bits are plain storage. The level lines come from registers. They are re-evaluated in the clock after any register write or any change on the request inputs, and they hold steady when nothing relevant changes.

The register port carries control, not a data stream, so it uses plain strobes and has no valid/ready handshake. A read strobe is always accepted and returns data one cycle later. A write strobe always takes effect at the next clock edge. Nothing on this port can stall.

Top module: `irq_level_mapper`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the control register, the read data and all sixteen level outputs to zero.
- R2: A write strobe stores all 8 bits of `reg_wdata`. A read strobe in cycle N puts the stored value on `reg_rdata` after the edge ending cycle N. When a read and a write share a cycle, the read returns the value held before the write.
- R3: With control bit 7 clear, request inputs 1, 2, 3, 4, 5 and 7 drive level outputs 1, 4, 6, 8, 10 and 14 respectively, one clock after the input rises.
- R4: Request inputs 0 and 6 map to level 0 and never raise any output. Output bit 0 is always low.
- R5: When control bit 7 is set, all level outputs are low one clock after the write. Clearing it brings back the lines of the sources still pending, one clock after that write.
- R6: Control bits 6 to 0 have no effect on the level outputs.
- R7: The inputs are level-sensitive. When a request input falls, its level line drops one clock later, unless another pending source maps to the same level.
- R8: Each level output is the OR of all pending sources mapped to it. Outputs 2, 3, 5, 7, 9, 11, 12, 13 and 15 are never raised.
- R9: Without a read strobe, `reg_rdata` holds its last value, even across writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_in | input | 8 | Level-sensitive request lines, bit i is source i |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_rd_en | input | 1 | Control register read strobe |
| reg_wdata | input | 8 | Write data, bit 7 is the global disable |
| reg_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| cpu_level | output | 16 | Per-priority request lines, bit n is level n |

## Verification
The mapping is tried in several ways: one source at a time, every one of the 256 request patterns with the switch off, and the same sweep with junk in the low control bits. These show whether a source lands on the wrong level or whether the low bits leak into gating. Pairs of sources are raised and dropped in turn. This separates a true OR per level from a last-writer value and checks that a line stays up while any contributor remains. Writes to the disable bit are toggled while requests are held steady, to confirm that gating follows the register and not the inputs.

// File: rtl/irq_map_pkg.sv
package irq_map_pkg;
  localparam int SRC_N = 8;
  localparam int LVL_N = 16;
  localparam int LVL_W = $clog2(LVL_N);
  localparam int CTRL_W = 8;
  localparam int DIS_BIT = 7;

  typedef logic [SRC_N-1:0] src_vec_t;
  typedef logic [LVL_N-1:0] lvl_vec_t;
  typedef logic [CTRL_W-1:0] ctrl_t;

  // priority assigned to each request source (0 = no interrupt)
  function automatic logic [LVL_W-1:0] src_level(input int s);
    case (s)
      1:       return LVL_W'(1);
      2:       return LVL_W'(4);
      3:       return LVL_W'(6);
      4:       return LVL_W'(8);
      5:       return LVL_W'(10);
      7:       return LVL_W'(14);
      default: return LVL_W'(0);
    endcase
  endfunction

  // levels that any source can reach, level 0 excluded
  function automatic lvl_vec_t reachable_levels();
    lvl_vec_t m;
    m = '0;
    for (int s = 0; s < SRC_N; s++) m[src_level(s)] = 1'b1;
    m[0] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/irq_pend_capture.sv
module irq_pend_capture
  import irq_map_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_vec_t irq_in,
  output src_vec_t pend_next,
  output logic     pend_change
);
  src_vec_t pend_q;

  assign pend_next   = irq_in;
  assign pend_change = (pend_next != pend_q);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_next;
  end
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_map_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  logic  rd_en,
  input  ctrl_t wdata,
  output ctrl_t rdata,
  output logic  dis_next
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wdata;
  end

  assign dis_next = ctrl_d[DIS_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      rdata  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (rd_en) rdata <= ctrl_q;
    end
  end
endmodule

// File: rtl/irq_level_drive.sv
module irq_level_drive
  import irq_map_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     eval_en,
  input  src_vec_t pend_next,
  input  logic     dis_next,
  output lvl_vec_t lvl_q
);
  lvl_vec_t lvl_d;

  for (genvar l = 0; l < LVL_N; l++) begin : g_lvl
    if (l == 0) begin : g_none
      assign lvl_d[l] = 1'b0;
    end else begin : g_or
      logic hit;
      always_comb begin
        hit = 1'b0;
        for (int s = 0; s < SRC_N; s++)
          if (src_level(s) == LVL_W'(l)) hit = hit | pend_next[s];
      end
      assign lvl_d[l] = hit & ~dis_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          lvl_q <= '0;
    else if (eval_en) lvl_q <= lvl_d;
  end
endmodule

// File: rtl/irq_level_mapper.sv
module irq_level_mapper
  import irq_map_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  irq_in,
  input  logic        reg_wr_en,
  input  logic        reg_rd_en,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic [15:0] cpu_level
);
  src_vec_t pend_next;
  logic     pend_change;
  logic     dis_next;

  irq_pend_capture u_pend (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .pend_next(pend_next), .pend_change(pend_change)
  );

  irq_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .wdata(reg_wdata), .rdata(reg_rdata), .dis_next(dis_next)
  );

  irq_level_drive u_drive (
    .clk(clk), .rst(rst), .eval_en(pend_change | reg_wr_en),
    .pend_next(pend_next), .dis_next(dis_next), .lvl_q(cpu_level)
  );
endmodule

// File: rtl/irq_level_mapper_chk.sv
module irq_level_mapper_chk
  import irq_map_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [7:0]  irq_in,
  input logic        reg_wr_en,
  input logic        reg_rd_en,
  input logic [7:0]  reg_wdata,
  input logic [7:0]  reg_rdata,
  input logic [15:0] cpu_level
);
  logic [7:0] shadow_ctrl;
  always_ff @(posedge clk) begin
    if (rst)            shadow_ctrl <= '0;
    else if (reg_wr_en) shadow_ctrl <= reg_wdata;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (cpu_level == '0 && reg_rdata == '0));

  p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_rd_en) && !$past(rst)) |-> reg_rdata == $past(shadow_ctrl));

  p_src7_level14_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_in[7]) && !$past(rst) && !shadow_ctrl[7]) |-> cpu_level[14]);

  p_level0_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !cpu_level[0]);

  p_gate_off_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_wr_en) && $past(reg_wdata[7])) |-> cpu_level == '0);

  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(irq_in) == '0) |-> cpu_level == '0);

  p_unmapped_r8: assert property (@(posedge clk) disable iff (rst)
    (cpu_level & ~reachable_levels()) == '0);

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(reg_rd_en) && !$past(rst)) |-> $stable(reg_rdata));
endmodule

bind irq_level_mapper irq_level_mapper_chk u_chk (
  .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr_en(reg_wr_en),
  .reg_rd_en(reg_rd_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .cpu_level(cpu_level)
);

// File: tb/irq_level_mapper_bench.sv
`timescale 1ns/100ps
module irq_level_mapper_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  irq_in = '0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [15:0] cpu_level;
  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  irq_level_mapper u_irq_level_mapper (
    .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr_en(reg_wr_en),
    .reg_rd_en(reg_rd_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_level(cpu_level)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [15:0] exp_lvl(input logic [7:0] p, input logic dis);
    logic [15:0] m;
    int lv;
    m = '0;
    if (dis) return m;
    for (int s = 0; s < 8; s++) begin
      case (s)
        1: lv = 1;  2: lv = 4;  3: lv = 6;  4: lv = 8;
        5: lv = 10; 7: lv = 14; default: lv = 0;
      endcase
      if (p[s] && lv != 0) m[lv] = 1'b1;
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); reg_wr_en = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); reg_rd_en = 1'b1;
    @(negedge clk); reg_rd_en = 1'b0;
  endtask

  task automatic t_reset();
    irq_in = 8'hFF;
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check("R1 level", cpu_level, 16'h0);
    check("R1 rdata", {8'h0, reg_rdata}, 16'h0);
    irq_in = '0;
    @(negedge clk); rst = 1'b0;
    rd();
    check("R1 ctrl", {8'h0, reg_rdata}, 16'h0);
  endtask

  task automatic t_reg_rw();
    wr(8'h3C); rd();
    check("R2 read 3C", {8'h0, reg_rdata}, 16'h003C);
    wr(8'hA5); rd();
    check("R2 read A5", {8'h0, reg_rdata}, 16'h00A5);
    @(negedge clk); reg_rd_en = 1'b1; reg_wr_en = 1'b1; reg_wdata = 8'h00;
    @(negedge clk); reg_rd_en = 1'b0; reg_wr_en = 1'b0;
    check("R2 read-during-write old", {8'h0, reg_rdata}, 16'h00A5);
    rd();
    check("R2 read after", {8'h0, reg_rdata}, 16'h0000);
  endtask

  task automatic t_single_sources();
    wr(8'h00);
    for (int s = 0; s < 8; s++) begin
      set_irq(8'(1 << s));
      check((s == 0 || s == 6) ? "R4 level0 source" : "R3 single source",
            cpu_level, exp_lvl(8'(1 << s), 1'b0));
    end
    set_irq(8'h41);
    check("R4 sources 0 and 6", cpu_level, 16'h0);
    set_irq(8'h00);
  endtask

  task automatic t_multi_or();
    set_irq(8'h84);
    check("R8 pair", cpu_level, 16'h4010);
    set_irq(8'h80);
    check("R7 drop one of pair", cpu_level, 16'h4000);
    set_irq(8'h00);
    check("R7 drop all", cpu_level, 16'h0);
  endtask

  task automatic t_disable();
    set_irq(8'hBE);
    check("R8 many", cpu_level, exp_lvl(8'hBE, 1'b0));
    wr(8'h80);
    check("R5 gate off", cpu_level, 16'h0);
    set_irq(8'hFF);
    check("R5 gate off input change", cpu_level, 16'h0);
    wr(8'h00);
    check("R5 gate on restores", cpu_level, exp_lvl(8'hFF, 1'b0));
    set_irq(8'h00);
  endtask

  task automatic t_low_bits();
    wr(8'h7F);
    for (int p = 0; p < 256; p++) begin
      set_irq(8'(p));
      check("R6 low bits no effect", cpu_level, exp_lvl(8'(p), 1'b0));
    end
    wr(8'h00);
  endtask

  task automatic t_sweep();
    for (int p = 0; p < 256; p++) begin
      set_irq(8'(p));
      check("R8 sweep", cpu_level, exp_lvl(8'(p), 1'b0));
    end
    wr(8'h81);
    for (int p = 0; p < 256; p += 17) begin
      set_irq(8'(p));
      check("R5 sweep gated", cpu_level, 16'h0);
    end
    wr(8'h00); set_irq(8'h00);
  endtask

  task automatic t_read_hold();
    wr(8'h5A); rd();
    check("R9 before", {8'h0, reg_rdata}, 16'h005A);
    wr(8'h12);
    repeat (3) @(negedge clk);
    check("R9 held across write", {8'h0, reg_rdata}, 16'h005A);
    rd();
    check("R9 new read", {8'h0, reg_rdata}, 16'h0012);
    wr(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_reg_rw();
    t_single_sources();
    t_multi_or();
    t_disable();
    t_low_bits();
    t_sweep();
    t_read_hold();
    t_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule